// File: doc/BRIEF.md
# One-Wire Byte Transfer Engine

This block adds byte-wide transfers on top of a one-wire bit-slot engine. Software writes a byte into a 16-bit data register. The engine then issues eight slot requests to the slot engine, least significant bit first. A 1-bit slot on a one-wire bus also samples the line, so the same eight slots build a received byte. Writing 0xFF therefore performs a plain byte read. A write-0 slot always reads back 0, because the bus is wired-AND.

Four flags track the transfer: transmit buffer empty, transmit shift register empty, receive buffer full and receive shift register full. An interrupt-enable register selects which flags drive a single registered interrupt line. The engine waits while the slot engine is busy with a bit-level operation. Reset and presence pulses and slot timing belong to the slot engine and are not part of this block.

Register addresses on `reg_addr`: 0 selects the data register, 1 the status register and 2 the interrupt-enable register.

Top module: `w1_byte_engine`

## Requirements
- R1: A byte is sent in eight slots, least significant bit first. Slot i carries bit i of the written byte on `slot_wbit`.
- R2: The line value returned in slot i (`slot_sample`) becomes bit i of the received byte. Writing 0xFF returns the device's byte, and a write-0 slot yields a 0 bit.
- R3: Status register layout: bit 2 is transmit buffer empty, bit 3 is transmit shift register empty, bit 4 is receive buffer full, bit 5 is receive shift register full. All other bits read 0. After reset the status reads 0x000C.
- R4: Writing the data register clears transmit-buffer-empty. The byte moves into the shift register, and the flag sets again, only when the shift register is empty. A second byte written during a transfer waits in the buffer.
- R5: Transmit-shift-register-empty is 0 while a byte is being shifted. It sets again once the eighth slot completes.
- R6: After the eighth slot, if the receive buffer is empty, the received byte enters it and receive-buffer-full sets. A data register read returns that byte in bits 7:0, with bits 15:8 zero, and clears receive-buffer-full.
- R7: If receive-buffer-full is still set when a byte completes, the byte stays in the receive shift register and receive-shift-register-full sets. Once the data register is read, that byte moves to the buffer and receive-shift-register-full clears.
- R8: No slot request is issued while `slot_busy` is high. Only one slot request is outstanding at a time, and each waits for `slot_done`.
- R9: `irq` is the OR of the status bits ANDed with the interrupt-enable bits, registered one cycle. The interrupt-enable register reads back its bits 5:2.
- R10: Register reads return data on `reg_rdata` in the cycle after `reg_rd` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select (0 data, 1 status, 2 interrupt enable) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid one cycle after the read strobe |
| irq | output | 1 | Masked interrupt request |
| slot_go | output | 1 | One-cycle request for a bit slot |
| slot_wbit | output | 1 | Bit to drive in the requested slot |
| slot_busy | input | 1 | Slot engine is occupied by a bit-level operation |
| slot_done | input | 1 | Requested slot finished |
| slot_sample | input | 1 | Line value sampled in the finished slot |

## Verification
The assertions check the local rules on every cycle:
- a data write drops transmit-buffer-empty;
- that flag rises only while the shift register is empty;
- a slot request is never issued while the slot engine is busy, and never two in a row;
- a data read with a full buffer clears it;
- the holding flag rises only over a full buffer;
- the interrupt line is high only when some enable bit is set.

The bench scenarios cover the whole-byte behaviour that no single-cycle property can show:
- the bit order on the wire;
- the wired-AND receive value;
- queuing of a second byte behind the first;
- hand-over of a held byte after a read;
- a stall under a busy slot engine;
- the interrupt mask over a full read cycle.

// File: rtl/w1b_pkg.sv
package w1b_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_IEN  = 2'd2;

  // status bit positions (decoded by software)
  localparam int ST_TBE  = 2;
  localparam int ST_TSRE = 3;
  localparam int ST_RBF  = 4;
  localparam int ST_RSRF = 5;

  localparam logic [REG_W-1:0] ST_MASK = 16'h003C;
endpackage

// File: rtl/w1b_shifter.sv
module w1b_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              tx_take,
  output logic              shift_empty,
  output logic              slot_go,
  output logic              slot_wbit,
  input  logic              slot_busy,
  input  logic              slot_done,
  input  logic              slot_sample,
  output logic              rx_done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              active;
  logic              pending;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_sr;
  logic [DATA_W-1:0] rx_next;

  assign tx_take     = tx_valid && !active;
  assign shift_empty = !active;
  assign slot_wbit   = tx_sr[0];
  assign rx_next     = {slot_sample, rx_sr[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      pending <= 1'b0;
      cnt     <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      rx_byte <= '0;
      rx_done <= 1'b0;
      slot_go <= 1'b0;
    end else begin
      slot_go <= 1'b0;
      rx_done <= 1'b0;
      if (tx_take) begin
        active  <= 1'b1;
        pending <= 1'b0;
        cnt     <= '0;
        tx_sr   <= tx_byte;
      end else if (active) begin
        if (!pending && !slot_busy) begin
          slot_go <= 1'b1;
          pending <= 1'b1;
        end else if (pending && slot_done) begin
          pending <= 1'b0;
          rx_sr   <= rx_next;
          tx_sr   <= tx_sr >> 1;
          cnt     <= cnt + 1'b1;
          if (cnt == LAST) begin
            active  <= 1'b0;
            rx_done <= 1'b1;
            rx_byte <= rx_next;
          end
        end
      end
    end
  end

  // R8
  no_busy_slot_chk: assert property (@(posedge clk) disable iff (rst)
    slot_go |-> $past(!slot_busy));
  // R8
  single_slot_chk: assert property (@(posedge clk) disable iff (rst)
    slot_go |=> !slot_go);
  // R5
  done_empty_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> shift_empty);
endmodule

// File: rtl/w1b_regs.sv
module w1b_regs
  import w1b_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_byte,
  input  logic              tx_take,
  input  logic              shift_empty,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte
);
  logic              tbe;
  logic              rbf;
  logic              rsrf;
  logic [DATA_W-1:0] tx_buf;
  logic [DATA_W-1:0] rx_buf;
  logic [DATA_W-1:0] rx_hold;
  logic [REG_W-1:0]  ien;
  logic [REG_W-1:0]  stat;
  logic              wr_data;
  logic              rd_data;

  assign wr_data  = reg_wr && (reg_addr == ADDR_DATA);
  assign rd_data  = reg_rd && (reg_addr == ADDR_DATA);
  assign tx_valid = !tbe;
  assign tx_byte  = tx_buf;

  always_comb begin
    stat          = '0;
    stat[ST_TBE]  = tbe;
    stat[ST_TSRE] = shift_empty;
    stat[ST_RBF]  = rbf;
    stat[ST_RSRF] = rsrf;
  end

  // transmit buffer
  always_ff @(posedge clk) begin
    if (rst) begin
      tbe    <= 1'b1;
      tx_buf <= '0;
    end else if (wr_data) begin
      tbe    <= 1'b0;
      tx_buf <= reg_wdata[DATA_W-1:0];
    end else if (tx_take) begin
      tbe    <= 1'b1;
    end
  end

  // receive buffer and holding stage
  always_ff @(posedge clk) begin
    if (rst) begin
      rbf     <= 1'b0;
      rsrf    <= 1'b0;
      rx_buf  <= '0;
      rx_hold <= '0;
    end else if (rx_done) begin
      if (!rbf) begin
        rbf <= 1'b1;
        if (rsrf) begin
          rx_buf  <= rx_hold;
          rx_hold <= rx_byte;
        end else begin
          rx_buf  <= rx_byte;
        end
      end else begin
        rx_hold <= rx_byte;
        rsrf    <= 1'b1;
        if (rd_data) rbf <= 1'b0;
      end
    end else if (rsrf && !rbf) begin
      rx_buf <= rx_hold;
      rbf    <= 1'b1;
      rsrf   <= 1'b0;
    end else if (rd_data) begin
      rbf <= 1'b0;
    end
  end

  // interrupt enable, interrupt and read data
  always_ff @(posedge clk) begin
    if (rst) begin
      ien       <= '0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && (reg_addr == ADDR_IEN)) ien <= reg_wdata & ST_MASK;
      irq <= |(stat & ien);
      if (reg_rd) begin
        case (reg_addr)
          ADDR_DATA: reg_rdata <= REG_W'(rx_buf);
          ADDR_STAT: reg_rdata <= stat;
          ADDR_IEN:  reg_rdata <= ien;
          default:   reg_rdata <= '0;
        endcase
      end else begin
        reg_rdata <= '0;
      end
    end
  end

  // R4
  wr_clears_tbe_chk: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> !tbe);
  // R4
  tbe_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tbe) |-> $past(shift_empty));
  // R6
  rd_clears_rbf_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data && rbf) |=> !rbf);
  // R7
  hold_over_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rsrf) |-> $past(rbf));
  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ien != '0));
endmodule

// File: rtl/w1_byte_engine.sv
module w1_byte_engine
  import w1b_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              slot_go,
  output logic              slot_wbit,
  input  logic              slot_busy,
  input  logic              slot_done,
  input  logic              slot_sample
);
  logic              tx_valid;
  logic              tx_take;
  logic              shift_empty;
  logic              rx_done;
  logic [DATA_W-1:0] tx_byte;
  logic [DATA_W-1:0] rx_byte;

  w1b_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq        (irq),
    .tx_valid   (tx_valid),
    .tx_byte    (tx_byte),
    .tx_take    (tx_take),
    .shift_empty(shift_empty),
    .rx_done    (rx_done),
    .rx_byte    (rx_byte)
  );

  w1b_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk        (clk),
    .rst        (rst),
    .tx_valid   (tx_valid),
    .tx_byte    (tx_byte),
    .tx_take    (tx_take),
    .shift_empty(shift_empty),
    .slot_go    (slot_go),
    .slot_wbit  (slot_wbit),
    .slot_busy  (slot_busy),
    .slot_done  (slot_done),
    .slot_sample(slot_sample),
    .rx_done    (rx_done),
    .rx_byte    (rx_byte)
  );
endmodule

// File: tb/w1_byte_engine_bench.sv
module w1_byte_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;
  logic        slot_go;
  logic        slot_wbit;
  logic        slot_busy = 1'b0;
  logic        slot_done = 1'b0;
  logic        slot_sample = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // slot engine model: wired-AND bus with a device byte
  logic [7:0]  dev_byte = 8'hFF;
  logic [15:0] wlog = '0;
  int          nslots = 0;
  int          sidx = 0;
  int          lat = 0;
  logic        wcur = 1'b0;

  w1_byte_engine u_w1_byte_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .slot_go(slot_go), .slot_wbit(slot_wbit),
    .slot_busy(slot_busy), .slot_done(slot_done), .slot_sample(slot_sample)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    slot_done = 1'b0;
    if (lat > 0) begin
      lat = lat - 1;
      if (lat == 0) begin
        slot_done   = 1'b1;
        slot_sample = wcur & dev_byte[sidx % 8];
        if (sidx < 16) wlog[sidx] = wcur;
        sidx = sidx + 1;
      end
    end
    if (slot_go) begin
      lat    = 3;
      wcur   = slot_wbit;
      nslots = nslots + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_stat(input logic [15:0] mask, input string tag);
    logic [15:0] s;
    bit seen = 0;
    for (int k = 0; k < 400 && !seen; k++) begin
      reg_read(2'd1, s);
      if ((s & mask) == mask) seen = 1;
    end
    chk(seen, tag, s, mask);
  endtask

  task automatic clear_log();
    @(negedge clk);
    sidx = 0; wlog = '0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    reg_read(2'd1, v);
    chk(v == 16'h000C, "R3 reset status", v, 16'h000C);
    reg_read(2'd0, v);
    chk(v == 16'h0000, "R10 reset data", v, 0);
    chk(irq == 1'b0, "R9 reset irq", irq, 0);
  endtask

  task automatic t_write_byte();
    logic [15:0] v;
    clear_log(); dev_byte = 8'hFF;
    reg_write(2'd0, 16'hAA5A);
    wait_stat(16'h0008, "R5 tsre after write");
    chk(wlog[7:0] == 8'h5A, "R1 lsb first", wlog[7:0], 8'h5A);
    wait_stat(16'h0010, "R6 rbf after byte");
    reg_read(2'd0, v);
    chk(v == 16'h005A, "R6 data read", v, 16'h005A);
    @(negedge clk);
    reg_read(2'd1, v);
    chk(v == 16'h000C, "R6 rbf cleared", v, 16'h000C);
  endtask

  task automatic t_read_byte();
    logic [15:0] v;
    clear_log(); dev_byte = 8'h3C;
    reg_write(2'd0, 16'h00FF);
    wait_stat(16'h0010, "R2 read rbf");
    reg_read(2'd0, v);
    chk(v == 16'h003C, "R2 read 0xFF", v, 16'h003C);
    clear_log();
    reg_write(2'd0, 16'h00F0);
    wait_stat(16'h0010, "R2 and rbf");
    reg_read(2'd0, v);
    chk(v == 16'h0030, "R2 write-0 slots read 0", v, 16'h0030);
  endtask

  task automatic t_tbe_timing();
    logic [15:0] v;
    clear_log(); dev_byte = 8'hFF;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0011;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b1; reg_addr = 2'd1;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
    chk(v == 16'h0008, "R4 tbe low after write", v, 16'h0008);
    reg_read(2'd1, v);
    chk(v == 16'h0004, "R5 shifting status", v, 16'h0004);
    wait_stat(16'h0010, "R6 byte done");
    reg_read(2'd0, v);
  endtask

  task automatic t_queue_and_hold();
    logic [15:0] v;
    clear_log(); dev_byte = 8'hFF;
    reg_write(2'd0, 16'h00C3);
    reg_write(2'd0, 16'h0096);
    reg_read(2'd1, v);
    chk(v == 16'h0000, "R4 second byte queued", v, 0);
    wait_stat(16'h0020, "R7 rsrf set");
    reg_read(2'd1, v);
    chk(v == 16'h003C, "R7 both full", v, 16'h003C);
    chk(wlog == 16'h96C3, "R4 order of queued bytes", wlog, 16'h96C3);
    reg_read(2'd0, v);
    chk(v == 16'h00C3, "R7 first byte", v, 16'h00C3);
    @(negedge clk);
    reg_read(2'd1, v);
    chk(v == 16'h001C, "R7 hold moved", v, 16'h001C);
    reg_read(2'd0, v);
    chk(v == 16'h0096, "R7 second byte", v, 16'h0096);
  endtask

  task automatic t_busy();
    logic [15:0] v;
    int n0;
    clear_log(); dev_byte = 8'hFF;
    @(negedge clk);
    slot_busy = 1'b1;
    n0 = nslots;
    reg_write(2'd0, 16'h005A);
    repeat (30) @(negedge clk);
    chk(nslots == n0, "R8 no slot while busy", nslots - n0, 0);
    reg_read(2'd1, v);
    chk(v == 16'h0004, "R8 stalled status", v, 16'h0004);
    slot_busy = 1'b0;
    wait_stat(16'h0010, "R8 resumes");
    chk(nslots == n0 + 8, "R8 eight slots", nslots - n0, 8);
    chk(wlog[7:0] == 8'h5A, "R1 bits after stall", wlog[7:0], 8'h5A);
    reg_read(2'd0, v);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    reg_write(2'd2, 16'hFFFF);
    reg_read(2'd2, v);
    chk(v == 16'h003C, "R9 enable readback", v, 16'h003C);
    reg_write(2'd2, 16'h0004);
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R9 irq on tbe", irq, 1);
    reg_write(2'd2, 16'h0010);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R9 irq masked", irq, 0);
    clear_log(); dev_byte = 8'h81;
    reg_write(2'd0, 16'h00FF);
    wait_stat(16'h0010, "R9 rbf");
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R9 irq on rbf", irq, 1);
    reg_read(2'd0, v);
    chk(v == 16'h0081, "R2 read 0x81", v, 16'h0081);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R9 irq after read", irq, 0);
    reg_write(2'd2, 16'h0000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_byte();
    t_read_byte();
    t_tbe_timing();
    t_queue_and_hold();
    t_busy();
    t_irq();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule